// File: doc/BRIEF.md
# Queue Machine Execute Unit (ALU and Shifter)

This block is the execute stage of a queue-based processor. The head entry of the operand queue arrives on `opa`, and the entry found a programmed distance behind the head arrives on `opb`. For shift instructions, a shift count taken from the instruction word arrives on `shamt`. An operation code selects one of nine functions. The block registers the 32-bit result for the write at the queue tail and raises a one-cycle valid strobe.

Arithmetic and bitwise operations take the head as the left-hand operand: the head is the minuend or the dividend. Shifts work on the offset operand and do not touch the head. Unsigned division by zero is defined: it returns all ones and raises a flag for that result only. Codes outside the nine defined functions return zero.

The shifter structure is chosen by the `SHIFT_IMPL` parameter. A value of 0 selects an explicit logarithmic barrel. A value of 1 uses the built-in shift operators.

Top module: `qexec_alu`

## Requirements
- R1: Operation code 0 gives `opa + opb` and code 1 gives `opa - opb`, both modulo 2^32.
- R2: Operation code 2 gives the low 32 bits of the unsigned product `opa * opb`.
- R3: Operation code 3 gives the unsigned quotient `opa / opb`, truncated, when `opb` is non-zero.
- R4: Operation code 3 with `opb` equal to zero gives 0xFFFFFFFF and sets `res_dbz` together with that result. `res_dbz` is low for every other result and in every cycle without a result.
- R5: Operation code 4 gives `opa & opb` and code 5 gives `opa | opb`.
- R6: Operation code 6 shifts `opb` right by `shamt` bits, filling with zeros. Code 7 shifts `opb` left by `shamt` bits, filling with zeros. A `shamt` of 0 returns `opb` unchanged, and `opa` has no effect on either shift.
- R7: Operation code 8 shifts `opb` right by `shamt` bits and fills the vacated bits with copies of `opb[31]`.
- R8: Operation codes 9 to 15 give a result of zero with `res_dbz` low.
- R9: `res_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. When no request is present, `res_data` keeps its previous value.
- R10: While `rst_n` is low, `res_valid`, `res_data` and `res_dbz` are all zero, whatever the request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Operation code (0 add, 1 sub, 2 mul, 3 div, 4 and, 5 or, 6 logical right, 7 logical left, 8 arithmetic right) |
| opa | input | 32 | Head operand |
| opb | input | 32 | Offset operand (entry behind the head) |
| shamt | input | 5 | Shift count from the instruction |
| res_valid | output | 1 | Registered result is new this cycle |
| res_data | output | 32 | Registered result for the queue tail |
| res_dbz | output | 1 | The current result came from a division by zero |

## Verification
The bench targets operand order. It uses subtraction and division with unequal operands, so a design that swapped head and offset would give a negated difference or an inverted quotient. It also uses a divisor with bit 31 set, which a signed divider would get wrong.

A division by zero is followed immediately by a legal division, so a divide-by-zero flag that stayed high would be seen. Shifts are issued with a count of zero and with the maximum count, and with an `opa` that differs from `opb`, so a shifter that used the head operand would give a different result. The arithmetic right shift is run on both positive and negative values of `opb` to catch a missing or always-on sign fill.

Idle gaps between requests expose a result register that does not hold its value or a valid strobe that stays high. Undefined operation codes must return zero, which catches a decoder that falls through to a neighbouring function.

// File: rtl/qexec_pkg.sv
package qexec_pkg;

   localparam int unsigned OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_MUL = 4'd2,
      OP_DIV = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_SRL = 4'd6,
      OP_SLL = 4'd7,
      OP_SRA = 4'd8
   } qop_e;

endpackage

// File: rtl/qexec_arith.sv
module qexec_arith #(
   parameter int W = 32
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic [W-1:0] result,
   output logic         div_zero
);

   logic [W-1:0] prod_lo;
   logic [W-1:0] quot;

   assign prod_lo  = lhs * rhs;
   assign div_zero = (rhs == '0);
   assign quot     = div_zero ? {W{1'b1}} : (lhs / rhs);

   always_comb begin
      unique case (sel)
         2'd0:    result = lhs + rhs;
         2'd1:    result = lhs - rhs;
         2'd2:    result = prod_lo;
         default: result = quot;
      endcase
   end

endmodule

// File: rtl/qexec_bitwise.sv
module qexec_bitwise #(
   parameter int W = 32
) (
   input  logic         use_or,
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic [W-1:0] result
);

   assign result = use_or ? (lhs | rhs) : (lhs & rhs);

endmodule

// File: rtl/qexec_shift.sv
module qexec_shift #(
   parameter int W    = 32,
   parameter int SW   = 5,
   parameter int IMPL = 0
) (
   input  logic [W-1:0]  val,
   input  logic [SW-1:0] amt,
   input  logic          go_left,
   input  logic          sign_fill,
   output logic [W-1:0]  out
);

   if (IMPL == 0) begin : g_barrel
      logic [W-1:0] src;
      logic [W-1:0] stg [SW+1];
      logic         fill;

      // A left shift is a right shift of the bit-reversed word.
      for (genvar i = 0; i < W; i++) begin : g_rev
         assign src[i] = go_left ? val[W-1-i] : val[i];
         assign out[i] = go_left ? stg[SW][W-1-i] : stg[SW][i];
      end

      assign fill   = sign_fill & ~go_left & val[W-1];
      assign stg[0] = src;

      for (genvar k = 0; k < SW; k++) begin : g_stage
         localparam int D = 1 << k;
         assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
      end
   end else begin : g_operator
      always_comb begin
         if (go_left)        out = val << amt;
         else if (sign_fill) out = $signed(val) >>> amt;
         else                out = val >> amt;
      end
   end

endmodule

// File: rtl/qexec_alu.sv
module qexec_alu #(
   parameter int DATA_W     = 32,
   parameter int SHAMT_W    = $clog2(DATA_W),
   parameter int SHIFT_IMPL = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [3:0]          req_op,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   input  logic [SHAMT_W-1:0]  shamt,
   output logic                res_valid,
   output logic [DATA_W-1:0]   res_data,
   output logic                res_dbz
);
   import qexec_pkg::*;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("qexec_alu: DATA_W must be a power of two of at least 8");
   end
   if (SHAMT_W != $clog2(DATA_W)) begin : g_bad_shamt
      $error("qexec_alu: SHAMT_W must equal clog2(DATA_W)");
   end
   if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
      $error("qexec_alu: SHIFT_IMPL must be 0 or 1");
   end

   qop_e               op;
   logic [DATA_W-1:0]  arith_res;
   logic [DATA_W-1:0]  bit_res;
   logic [DATA_W-1:0]  shift_res;
   logic               rhs_zero;
   logic [DATA_W-1:0]  next_res;
   logic               next_dbz;

   assign op = qop_e'(req_op);

   qexec_arith #(.W(DATA_W)) u_arith (
      .sel      (req_op[1:0]),
      .lhs      (opa),
      .rhs      (opb),
      .result   (arith_res),
      .div_zero (rhs_zero)
   );

   qexec_bitwise #(.W(DATA_W)) u_bitwise (
      .use_or (req_op[0]),
      .lhs    (opa),
      .rhs    (opb),
      .result (bit_res)
   );

   qexec_shift #(.W(DATA_W), .SW(SHAMT_W), .IMPL(SHIFT_IMPL)) u_shift (
      .val       (opb),
      .amt       (shamt),
      .go_left   (op == OP_SLL),
      .sign_fill (op == OP_SRA),
      .out       (shift_res)
   );

   always_comb begin
      next_dbz = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_MUL: next_res = arith_res;
         OP_DIV: begin
            next_res = arith_res;
            next_dbz = rhs_zero;
         end
         OP_AND, OP_OR:          next_res = bit_res;
         OP_SRL, OP_SLL, OP_SRA: next_res = shift_res;
         default:                next_res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_dbz   <= 1'b0;
      end else begin
         res_valid <= req_valid;
         res_dbz   <= req_valid & next_dbz;
         if (req_valid) res_data <= next_res;
      end
   end

endmodule

// File: rtl/qexec_alu_chk.sv
module qexec_alu_chk #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [3:0]         req_op,
   input logic [DATA_W-1:0]  opa,
   input logic [DATA_W-1:0]  opb,
   input logic [SHAMT_W-1:0] shamt,
   input logic               res_valid,
   input logic [DATA_W-1:0]  res_data,
   input logic               res_dbz
);

   p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   p_valid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_data));

   p_dbz_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 4'd3 && opb == '0) |=> (res_dbz && res_data == {DATA_W{1'b1}}));

   p_dbz_only_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_dbz |-> res_valid);

   p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op > 4'd8) |=> (res_data == '0 && !res_dbz));

   p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 4'd4) |=> (res_data == ($past(opa) & $past(opb))));

   p_shift_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op >= 4'd6 && req_op <= 4'd8 && shamt == '0) |=> (res_data == $past(opb)));

endmodule

bind qexec_alu qexec_alu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (.*);

// File: tb/qexec_alu_tb.sv
`timescale 1ns/1ps
module qexec_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_op = '0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [4:0]  shamt = '0;
   logic        res_valid;
   logic [31:0] res_data;
   logic        res_dbz;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic        exp_v = 1'b0;
   logic [31:0] exp_d = '0;
   logic        exp_z = 1'b0;
   string       exp_tag = "R10";

   always #4 clk = ~clk;

   qexec_alu u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .opa(opa), .opb(opb), .shamt(shamt),
      .res_valid(res_valid), .res_data(res_data), .res_dbz(res_dbz)
   );

   function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                         input logic [31:0] b, input int s);
      longint unsigned la = a;
      longint unsigned lb = b;
      logic [31:0] r;
      case (op)
         0: r = 32'((la + lb) & 64'hFFFF_FFFF);
         1: r = 32'((la - lb) & 64'hFFFF_FFFF);
         2: r = 32'((la * lb) & 64'hFFFF_FFFF);
         3: r = (lb == 0) ? 32'hFFFF_FFFF : 32'(la / lb);
         4: r = a & b;
         5: r = a | b;
         6: begin r = b; for (int i = 0; i < s; i++) r = {1'b0, r[31:1]}; end
         7: begin r = b; for (int i = 0; i < s; i++) r = {r[30:0], 1'b0}; end
         8: begin r = b; for (int i = 0; i < s; i++) r = {r[31], r[31:1]}; end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input int op, input logic [31:0] b);
      case (op)
         0, 1: return "R1";
         2:    return "R2";
         3:    return (b == 0) ? "R4" : "R3";
         4, 5: return "R5";
         6, 7: return "R6";
         8:    return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic compare_now();
      checks += 3;
      if (res_valid !== exp_v) begin
         fails++;
         $display("FAIL %s/R9 res_valid actual=%b expected=%b", exp_tag, res_valid, exp_v);
      end
      if (res_data !== exp_d) begin
         fails++;
         $display("FAIL %s res_data actual=%h expected=%h", exp_tag, res_data, exp_d);
      end
      if (res_dbz !== exp_z) begin
         fails++;
         $display("FAIL %s/R4 res_dbz actual=%b expected=%b", exp_tag, res_dbz, exp_z);
      end
   endtask

   // One cycle: check the outputs due now, then present the next request.
   task automatic step(input bit v, input int op, input logic [31:0] a,
                       input logic [31:0] b, input int s);
      @(negedge clk);
      compare_now();
      req_valid = v;
      req_op    = 4'(op);
      opa       = a;
      opb       = b;
      shamt     = 5'(s);
      exp_v     = v;
      exp_z     = v && (op == 3) && (b == 0);
      if (v) begin
         exp_d   = model(op, a, b, s);
         exp_tag = tag_of(op, b);
      end else begin
         exp_tag = "R9";
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      // R10: reset holds outputs at zero even with a request present
      req_valid = 1'b1; req_op = 4'd3; opa = 32'h55; opb = 32'h0;
      repeat (3) @(negedge clk);
      exp_tag = "R10";
      compare_now();
      @(negedge clk);
      compare_now();
      req_valid = 1'b0;
      rst_n = 1'b1;

      // R1 wrap and operand order
      step(1, 0, 32'hFFFF_FFFF, 32'h1, 0);
      step(1, 1, 32'd3, 32'd5, 0);
      step(1, 1, 32'd100, 32'd1, 7);
      // R2 low half of product
      step(1, 2, 32'h0001_0000, 32'h0001_0000, 0);
      step(1, 2, 32'hFFFF_FFFF, 32'd2, 0);
      // R3 unsigned truncating division, head is dividend
      step(1, 3, 32'd100, 32'd7, 0);
      step(1, 3, 32'd7, 32'd100, 0);
      step(1, 3, 32'h8000_0000, 32'd2, 0);
      step(1, 3, 32'hFFFF_FFF0, 32'h8000_0000, 0);
      // R4 divide by zero then a legal divide: flag for one result only
      step(1, 3, 32'd5, 32'd0, 0);
      step(1, 3, 32'd6, 32'd3, 0);
      step(1, 3, 32'd0, 32'd0, 0);
      step(0, 3, 32'd9, 32'd0, 0);
      // R5 bitwise
      step(1, 4, 32'hF0F0_1234, 32'hFF00_FF00, 0);
      step(1, 5, 32'hF0F0_1234, 32'h0F00_00C1, 0);
      // R6 logical shifts of the offset operand
      step(1, 6, 32'hDEAD_BEEF, 32'h8000_0000, 31);
      step(1, 7, 32'hDEAD_BEEF, 32'h1234_5678, 0);
      step(1, 6, 32'h0, 32'hCAFE_F00D, 0);
      step(1, 7, 32'hFFFF_FFFF, 32'h0000_0003, 31);
      step(1, 7, 32'h1, 32'h00FF_00FF, 8);
      // R7 arithmetic right shift, both signs
      step(1, 8, 32'h0, 32'h8000_0000, 4);
      step(1, 8, 32'hFFFF_FFFF, 32'h4000_0000, 30);
      step(1, 8, 32'h0, 32'hFFFF_FFFE, 31);
      step(1, 8, 32'h0, 32'h8765_4321, 0);
      // R8 undefined codes
      step(1, 9, 32'h1234, 32'h0, 3);
      step(1, 15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
      // R9 idle gaps hold result
      step(1, 0, 32'd40, 32'd2, 0);
      step(0, 1, 32'd0, 32'd0, 0);
      step(0, 2, 32'd9, 32'd9, 0);
      step(1, 5, 32'h1, 32'h2, 0);

      // Mixed traffic
      for (int n = 0; n < 400; n++) begin
         logic [31:0] b;
         b = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom;
         step($urandom_range(0, 4) != 0, int'($urandom_range(0, 15)), $urandom, b,
              int'($urandom_range(0, 31)));
      end
      step(0, 0, 32'h0, 32'h0, 0);
      step(0, 0, 32'h0, 32'h0, 0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

endmodule